// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a circular ring of two-word transmit descriptors kept in a synchronous memory that has a one-cycle read latency. Software fills descriptors, hands each one to hardware through an ownership bit, and then writes a pending command. For every descriptor that hardware owns, the engine reads the flag word and the buffer address. Where the byte count is not zero, it issues a buffer command on a valid/ready interface. It then writes the flag word back with ownership returned to software and moves on to the next entry.

The ring pointer is a base plus a displacement, and the ring size is programmable in steps of 16 entries. The engine stops at the first descriptor that software still owns. At that point it can raise two events: an all-done event and a missing end-of-packet error event. In drain mode the all-done event is held back until an external FIFO-empty input is high.

Top module: `txring_engine`

## Requirements
- R1: After reset, all four registers read 0, no memory access or buffer command is issued, and neither event is asserted.
- R2: Register 0 bit 0 is the pending command. Writing 1 sets it, and it reads back as 1 until the engine accepts it, then clears itself. Register 1 holds the configuration: bit 0 is the DMA enable and bit 1 is drain mode. While the enable is 0, a pending command stays set and no memory access occurs.
- R3: The memory word address is {base, displacement, slot}. Slot 0 holds the flag word and slot 1 holds the buffer address. In the flag word, bits 13:0 are the byte count, bit 29 marks end-of-packet, bit 30 marks start-of-packet, and bit 31 is ownership (1 means hardware owns it).
- R4: Each hardware-owned descriptor with a non-zero count produces exactly one buffer command, in ring order, carrying the buffer address, the count, the start flag and the end flag. The command is held stable while valid is high and ready is low, and no memory access occurs while it is pending.
- R5: After its command is accepted, each descriptor's flag word is written back with bit 31 cleared and bits 30:0 unchanged. The buffer address word is never written.
- R6: A hardware-owned descriptor with a count of 0 produces no buffer command but is still written back.
- R7: The engine stops at the first descriptor whose bit 31 is 0 and leaves that descriptor unchanged. Register 2 (base in bits 28:8, displacement in bits 7:0) then reads back that descriptor's displacement.
- R8: Register 3 bits 3:0 hold the size field s, which gives a ring of (s+1)*16 entries. The displacement wraps from the last entry to 0.
- R9: With drain mode off, all-done is a one-cycle pulse in the cycle after the stop. It fires only when at least one descriptor was processed in that run.
- R10: With drain mode on, all-done is asserted only while FIFO-empty is high. It stays pending until then.
- R11: The end-of-packet error event is a one-cycle pulse at the stop when the last descriptor processed in the run had bit 29 clear.
- R12: If the enable is cleared during a run, the engine finishes the descriptor in progress, including its write-back, and then stops without raising all-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor memory access |
| mem_we | output | 1 | Memory write (write-back) |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |
| cmd_valid | output | 1 | Buffer command valid |
| cmd_ready | input | 1 | Buffer command accepted |
| cmd_addr | output | 32 | Buffer address |
| cmd_len | output | 14 | Buffer byte count |
| cmd_sop | output | 1 | First buffer of a packet |
| cmd_eop | output | 1 | Last buffer of a packet |
| fifo_empty | input | 1 | Downstream FIFO is empty (drain mode) |
| all_done | output | 1 | Ring walk finished event |
| eop_err | output | 1 | Missing end-of-packet event |

## Verification
A wrong displacement shows up in the next memory address. It also shows in the pointer readback once the run stops, so a bad wrap corrupts the descriptor that follows within about five cycles of the edge. A lost or stale flag latch appears as a wrong command field or a wrong write-back word for the same descriptor. A wrong packet-tracking bit or event-arming bit only shows at the stop: the event pulse in the cycle after the stop is then missing or extra, or in drain mode it appears while the FIFO is not empty.

// File: rtl/txr_pkg.sv
package txr_pkg;
   timeunit 1ns; timeprecision 100ps;

   // flag word bit positions (software decodes these)
   localparam int unsigned OWN_BIT = 31;
   localparam int unsigned SOP_BIT = 30;
   localparam int unsigned EOP_BIT = 29;

   // register selects
   localparam logic [1:0] RA_PEND = 2'd0;
   localparam logic [1:0] RA_CFG  = 2'd1;
   localparam logic [1:0] RA_PTR  = 2'd2;
   localparam logic [1:0] RA_SIZE = 2'd3;

   typedef enum logic [2:0] {
      W_IDLE, W_RDF, W_CHK, W_ADR, W_CMD, W_WB
   } walk_state_t;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
   import txr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BASE_W = 21,
   parameter int unsigned DISP_W = 8,
   parameter int unsigned SIZE_W = 4,
   localparam int unsigned PTR_W = BASE_W + DISP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              pend_ack_i,
   input  logic [DISP_W-1:0] disp_i,
   output logic              pend_o,
   output logic              dma_en_o,
   output logic              drain_o,
   output logic [BASE_W-1:0] base_o,
   output logic [SIZE_W-1:0] size_o,
   output logic              ptr_load_o,
   output logic [DISP_W-1:0] ptr_disp_o
);
   timeunit 1ns; timeprecision 100ps;

   generate
      if (PTR_W >= DATA_W) begin : g_bad_ptr
         $error("pointer field does not fit the data word");
      end
   endgenerate

   logic pend_q, en_q, drain_q;
   logic [BASE_W-1:0] base_q;
   logic [SIZE_W-1:0] size_q;
   logic set_pend;
   logic unused_wbits;

   assign unused_wbits = ^reg_wdata[DATA_W-1:PTR_W];
   assign set_pend     = reg_wr && (reg_addr == RA_PEND) && reg_wdata[0];
   assign ptr_load_o   = reg_wr && (reg_addr == RA_PTR);
   assign ptr_disp_o   = reg_wdata[DISP_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         en_q    <= 1'b0;
         drain_q <= 1'b0;
         base_q  <= '0;
         size_q  <= '0;
      end else begin
         // a new command in the acceptance cycle is not lost
         pend_q <= (pend_q && !pend_ack_i) || set_pend;
         if (reg_wr && reg_addr == RA_CFG) begin
            en_q    <= reg_wdata[0];
            drain_q <= reg_wdata[1];
         end
         if (ptr_load_o)
            base_q <= reg_wdata[PTR_W-1:DISP_W];
         if (reg_wr && reg_addr == RA_SIZE)
            size_q <= reg_wdata[SIZE_W-1:0];
      end
   end

   always_comb begin
      case (reg_addr)
         RA_PEND: reg_rdata = DATA_W'(pend_q);
         RA_CFG:  reg_rdata = DATA_W'({drain_q, en_q});
         RA_PTR:  reg_rdata = DATA_W'({base_q, disp_i});
         default: reg_rdata = DATA_W'(size_q);
      endcase
   end

   assign pend_o   = pend_q;
   assign dma_en_o = en_q;
   assign drain_o  = drain_q;
   assign base_o   = base_q;
   assign size_o   = size_q;
endmodule

// File: rtl/txr_walker.sv
module txr_walker
   import txr_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 14,
   parameter int unsigned BASE_W  = 21,
   parameter int unsigned DISP_W  = 8,
   parameter int unsigned SIZE_W  = 4,
   parameter int unsigned STEP_LG = 4,
   localparam int unsigned MEM_AW = BASE_W + DISP_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pend_i,
   input  logic              dma_en_i,
   input  logic [BASE_W-1:0] base_i,
   input  logic [SIZE_W-1:0] size_i,
   input  logic              ptr_load_i,
   input  logic [DISP_W-1:0] ptr_disp_i,
   output logic              pend_ack_o,
   output logic [DISP_W-1:0] disp_o,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [DATA_W-1:0] cmd_addr,
   output logic [CNT_W-1:0]  cmd_len,
   output logic              cmd_sop,
   output logic              cmd_eop,
   output logic              run_end_o,
   output logic              miss_eop_o
);
   timeunit 1ns; timeprecision 100ps;

   generate
      if (SIZE_W + STEP_LG > DISP_W) begin : g_bad_ring
         $error("largest ring exceeds the displacement range");
      end
      if (DATA_W < 32 || CNT_W > EOP_BIT) begin : g_bad_flags
         $error("flag word layout does not fit");
      end
   endgenerate

   walk_state_t st_q;
   logic [DISP_W-1:0] disp_q, disp_last, disp_nxt;
   logic [DISP_W:0]   ent_cnt;
   logic [DATA_W-1:0] flags_q, baddr_q;
   logic did_q, inpkt_q, stop;
   logic [DATA_W-1:0] own_mask;

   assign own_mask  = DATA_W'(1) << OWN_BIT;
   assign ent_cnt   = ((DISP_W+1)'(size_i) + (DISP_W+1)'(1)) << STEP_LG;
   assign disp_last = DISP_W'(ent_cnt - (DISP_W+1)'(1));
   assign disp_nxt  = (disp_q == disp_last) ? '0 : disp_q + DISP_W'(1);

   assign stop       = (st_q == W_CHK) && !mem_rdata[OWN_BIT];
   assign run_end_o  = stop && did_q;
   assign miss_eop_o = stop && inpkt_q;
   assign pend_ack_o = (st_q == W_IDLE) && pend_i && dma_en_i;

   assign mem_req   = (st_q == W_RDF) || (st_q == W_WB) ||
                      ((st_q == W_CHK) && mem_rdata[OWN_BIT]);
   assign mem_we    = (st_q == W_WB);
   assign mem_addr  = {base_i, disp_q, (st_q == W_CHK)};
   assign mem_wdata = flags_q & ~own_mask;

   assign cmd_valid = (st_q == W_CMD);
   assign cmd_addr  = baddr_q;
   assign cmd_len   = flags_q[CNT_W-1:0];
   assign cmd_sop   = flags_q[SOP_BIT];
   assign cmd_eop   = flags_q[EOP_BIT];
   assign disp_o    = disp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= W_IDLE;
         disp_q  <= '0;
         flags_q <= '0;
         baddr_q <= '0;
         did_q   <= 1'b0;
         inpkt_q <= 1'b0;
      end else begin
         case (st_q)
            W_IDLE: if (pend_ack_o) begin
               st_q  <= W_RDF;
               did_q <= 1'b0;
            end
            W_RDF: st_q <= W_CHK;
            W_CHK: if (mem_rdata[OWN_BIT]) begin
               flags_q <= mem_rdata;
               st_q    <= W_ADR;
            end else begin
               inpkt_q <= 1'b0;
               st_q    <= W_IDLE;
            end
            W_ADR: begin
               baddr_q <= mem_rdata;
               st_q    <= (flags_q[CNT_W-1:0] != '0) ? W_CMD : W_WB;
            end
            W_CMD: if (cmd_ready) st_q <= W_WB;
            W_WB: begin
               disp_q  <= disp_nxt;
               did_q   <= 1'b1;
               inpkt_q <= !flags_q[EOP_BIT];
               st_q    <= dma_en_i ? W_RDF : W_IDLE;
            end
            default: st_q <= W_IDLE;
         endcase
         if (ptr_load_i)
            disp_q <= ptr_disp_i;
      end
   end
endmodule

// File: rtl/txr_events.sv
module txr_events (
   input  logic clk,
   input  logic rst_n,
   input  logic run_end_i,
   input  logic miss_eop_i,
   input  logic drain_i,
   input  logic fifo_empty,
   output logic all_done,
   output logic eop_err
);
   timeunit 1ns; timeprecision 100ps;

   logic arm_q, err_q;

   assign all_done = arm_q && (!drain_i || fifo_empty);
   assign eop_err  = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         arm_q <= (arm_q && !all_done) || run_end_i;
         err_q <= miss_eop_i;
      end
   end
endmodule

// File: rtl/txring_engine.sv
module txring_engine
   import txr_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 14,
   parameter int unsigned BASE_W  = 21,
   parameter int unsigned DISP_W  = 8,
   parameter int unsigned SIZE_W  = 4,
   parameter int unsigned STEP_LG = 4,
   localparam int unsigned MEM_AW = BASE_W + DISP_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [DATA_W-1:0] cmd_addr,
   output logic [CNT_W-1:0]  cmd_len,
   output logic              cmd_sop,
   output logic              cmd_eop,
   input  logic              fifo_empty,
   output logic              all_done,
   output logic              eop_err
);
   timeunit 1ns; timeprecision 100ps;

   logic pend, pend_ack, dma_en, cfg_drain, ptr_load, run_end, miss_eop;
   logic [BASE_W-1:0] base;
   logic [SIZE_W-1:0] size;
   logic [DISP_W-1:0] disp, ptr_disp;

   txr_regs #(
      .DATA_W(DATA_W), .BASE_W(BASE_W), .DISP_W(DISP_W), .SIZE_W(SIZE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pend_ack_i(pend_ack),
      .disp_i(disp), .pend_o(pend), .dma_en_o(dma_en), .drain_o(cfg_drain),
      .base_o(base), .size_o(size), .ptr_load_o(ptr_load), .ptr_disp_o(ptr_disp)
   );

   txr_walker #(
      .DATA_W(DATA_W), .CNT_W(CNT_W), .BASE_W(BASE_W), .DISP_W(DISP_W),
      .SIZE_W(SIZE_W), .STEP_LG(STEP_LG)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .dma_en_i(dma_en),
      .base_i(base), .size_i(size), .ptr_load_i(ptr_load), .ptr_disp_i(ptr_disp),
      .pend_ack_o(pend_ack), .disp_o(disp), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
      .cmd_len(cmd_len), .cmd_sop(cmd_sop), .cmd_eop(cmd_eop),
      .run_end_o(run_end), .miss_eop_o(miss_eop)
   );

   txr_events u_evt (
      .clk(clk), .rst_n(rst_n), .run_end_i(run_end), .miss_eop_i(miss_eop),
      .drain_i(cfg_drain), .fifo_empty(fifo_empty), .all_done(all_done),
      .eop_err(eop_err)
   );
endmodule

// File: rtl/txring_checker.sv
module txring_checker #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [DATA_W-1:0] cmd_addr,
   input logic [CNT_W-1:0]  cmd_len,
   input logic              cmd_sop,
   input logic              cmd_eop,
   input logic              mem_req,
   input logic              mem_we,
   input logic              wb_slot,
   input logic              wb_own,
   input logic              fifo_empty,
   input logic              drain,
   input logic              all_done,
   input logic              eop_err
);
   timeunit 1ns; timeprecision 100ps;

   assert_cmd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) &&
         $stable(cmd_len) && $stable(cmd_sop) && $stable(cmd_eop)));

   assert_no_mem_in_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> !mem_req);

   assert_wb_flag_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !wb_slot);

   assert_wb_own_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !wb_own);

   assert_done_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      all_done |-> (!drain || fifo_empty));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      all_done |=> !all_done);

   assert_eop_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      eop_err |=> !eop_err);
endmodule

bind txring_engine txring_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_sop(cmd_sop), .cmd_eop(cmd_eop),
   .mem_req(mem_req), .mem_we(mem_we), .wb_slot(mem_addr[0]),
   .wb_own(mem_wdata[31]), .fifo_empty(fifo_empty), .drain(cfg_drain),
   .all_done(all_done), .eop_err(eop_err)
);

// File: tb/sim_txring_engine.sv
module sim_txring_engine;
   timeunit 1ns; timeprecision 100ps;

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic mem_req, mem_we;
   logic [29:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata = '0;
   logic cmd_valid, cmd_ready = 1'b1, cmd_sop, cmd_eop;
   logic [31:0] cmd_addr;
   logic [13:0] cmd_len;
   logic fifo_empty = 1'b1, all_done, eop_err;

   always #4 clk = ~clk; // 125 MHz

   txring_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_sop(cmd_sop),
      .cmd_eop(cmd_eop), .fifo_empty(fifo_empty), .all_done(all_done),
      .eop_err(eop_err)
   );

   localparam logic [20:0] BASE = 21'h0A5C3;
   int checks = 0, errors = 0, cyc = 0, ready_mode = 0;
   int n_cmd = 0, done_cnt = 0, err_cnt = 0, mem_acc = 0;
   bit addr_bad = 0;
   logic [31:0] bmem [0:511];
   logic [31:0] log_addr [0:63];
   logic [13:0] log_len [0:63];
   logic log_sop [0:63], log_eop [0:63];
   logic [31:0] exp_flags [0:63], exp_baddr [0:63];

   // descriptor memory model, one-cycle read latency
   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) bmem[mem_addr[8:0]] <= mem_wdata;
         else        mem_rdata <= bmem[mem_addr[8:0]];
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      #1;
      case (ready_mode)
         0: cmd_ready = 1'b1;
         1: cmd_ready = cyc[0];
         2: cmd_ready = (cyc % 3 == 0);
         default: cmd_ready = 1'b0;
      endcase
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid && cmd_ready && n_cmd < 64) begin
            log_addr[n_cmd] = cmd_addr; log_len[n_cmd] = cmd_len;
            log_sop[n_cmd] = cmd_sop;   log_eop[n_cmd] = cmd_eop;
            n_cmd++;
         end
         if (all_done) done_cnt++;
         if (eop_err) err_cnt++;
         if (mem_req) begin
            mem_acc++;
            if (mem_addr[29:9] != BASE) addr_bad = 1;
         end
      end
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      if (cyc > 100000) begin
         checks++; errors++;
         $display("FAIL watchdog R1 actual=%0d expected=<100000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a; #1;
      d = reg_rdata;
   endtask

   task automatic clear_logs();
      n_cmd = 0; done_cnt = 0; err_cnt = 0; mem_acc = 0; addr_bad = 0;
   endtask

   // fills nd owned descriptors from start, then a software-owned stopper
   task automatic fill_ring(input int start, input int nd, input int ent,
                            input bit eop_last);
      bit prev_eop = 1'b1;
      for (int k = 0; k < nd; k++) begin
         int idx = (start + k) % ent;
         logic [13:0] len = (k % 4 == 2) ? 14'd0 : 14'((k * 97 + idx * 13 + 1));
         bit eop = (k == nd - 1) ? eop_last : (k % 3 == 1);
         bit sop = prev_eop;
         exp_flags[k] = {1'b1, sop, eop, 15'(k * 5 + 3), len};
         exp_baddr[k] = 32'hA000_0000 + 32'(idx * 64 + k);
         bmem[idx * 2]     = exp_flags[k];
         bmem[idx * 2 + 1] = exp_baddr[k];
         prev_eop = eop;
      end
      bmem[((start + nd) % ent) * 2]     = 32'h0000_1234;
      bmem[((start + nd) % ent) * 2 + 1] = 32'h5555_AAAA;
   endtask

   task automatic do_run(input int start, input int nd, input int sz,
                         input bit drain, input int rmode, input bit eop_last,
                         input string req);
      int ent = (sz + 1) * 16;
      int ncmd_exp = 0, j = 0;
      int stop_idx = (start + nd) % ent;
      logic [31:0] rd;
      reg_write(2'd3, 32'(sz));
      reg_write(2'd2, {3'b0, BASE, 8'(start)});
      fill_ring(start, nd, ent, eop_last);
      ready_mode = rmode;
      fifo_empty = !drain;
      reg_write(2'd1, {30'b0, drain, 1'b1});
      clear_logs();
      reg_write(2'd0, 32'h1);
      wait_cyc(nd * 12 + 30);
      if (drain) begin
         chk(done_cnt == 0, "R10", "done held while fifo busy", done_cnt, 0);
         fifo_empty = 1'b1;
         wait_cyc(3);
      end
      chk(done_cnt == int'(nd > 0), drain ? "R10" : "R9", {req, " all_done count"},
          done_cnt, int'(nd > 0));
      chk(err_cnt == int'(nd > 0 && !eop_last), "R11", {req, " eop_err count"},
          err_cnt, int'(nd > 0 && !eop_last));
      for (int k = 0; k < nd; k++) if (exp_flags[k][13:0] != 0) ncmd_exp++;
      chk(n_cmd == ncmd_exp, "R6", {req, " command count"}, n_cmd, ncmd_exp);
      for (int k = 0; k < nd; k++) begin
         int idx = (start + k) % ent;
         if (exp_flags[k][13:0] != 0 && j < n_cmd) begin
            chk(log_addr[j] == exp_baddr[k] && log_len[j] == exp_flags[k][13:0] &&
                log_sop[j] == exp_flags[k][30] && log_eop[j] == exp_flags[k][29],
                "R4", {req, " command fields"},
                {log_addr[j], log_len[j], log_sop[j], log_eop[j]},
                {exp_baddr[k], exp_flags[k][13:0], exp_flags[k][30], exp_flags[k][29]});
            j++;
         end
         chk(bmem[idx * 2] == (exp_flags[k] & 32'h7FFF_FFFF), "R5", {req, " write-back"},
             bmem[idx * 2], exp_flags[k] & 32'h7FFF_FFFF);
         chk(bmem[idx * 2 + 1] == exp_baddr[k], "R5", {req, " address word kept"},
             bmem[idx * 2 + 1], exp_baddr[k]);
      end
      chk(bmem[stop_idx * 2] == 32'h0000_1234, "R7", {req, " stopper untouched"},
          bmem[stop_idx * 2], 32'h0000_1234);
      reg_read(2'd2, rd);
      chk(rd == {3'b0, BASE, 8'(stop_idx)}, "R8", {req, " pointer after run"},
          rd, {3'b0, BASE, 8'(stop_idx)});
      reg_read(2'd0, rd);
      chk(rd == 32'h0, "R2", {req, " pending cleared"}, rd, 0);
      chk(!addr_bad, "R3", {req, " memory address base"}, addr_bad, 0);
   endtask

   initial begin
      logic [31:0] rd;
      for (int i = 0; i < 512; i++) bmem[i] = '0;
      wait_cyc(5);
      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         reg_read(2'(a), rd);
         chk(rd == 0, "R1", "register after reset", rd, 0);
      end
      chk(!cmd_valid && !mem_req && !all_done && !eop_err, "R1", "outputs idle",
          {cmd_valid, mem_req, all_done, eop_err}, 0);
      rst_n = 1'b1;
      wait_cyc(2);

      // R2: pending held while disabled
      clear_logs();
      reg_write(2'd2, {3'b0, BASE, 8'd0});
      reg_write(2'd0, 32'h1);
      wait_cyc(10);
      reg_read(2'd0, rd);
      chk(rd == 1, "R2", "pending held while disabled", rd, 1);
      chk(mem_acc == 0, "R2", "no access while disabled", mem_acc, 0);
      reg_write(2'd1, 32'h1);
      wait_cyc(10);
      reg_read(2'd0, rd);
      chk(rd == 0, "R2", "pending accepted once enabled", rd, 0);
      chk(done_cnt == 0 && n_cmd == 0, "R9", "empty run gives no done",
          done_cnt + n_cmd, 0);

      do_run(0,   5,  0,  1'b0, 0, 1'b1, "R4 basic");
      do_run(12,  9,  0,  1'b0, 1, 1'b0, "R8 wrap16");
      do_run(30,  6,  1,  1'b0, 2, 1'b1, "R8 wrap32");
      do_run(250, 10, 15, 1'b0, 0, 1'b1, "R8 wrap256");
      do_run(3,   7,  0,  1'b1, 2, 1'b1, "R10 drain");
      do_run(3,   0,  0,  1'b0, 0, 1'b1, "R9 none");
      do_run(60,  12, 3,  1'b0, 1, 1'b0, "R11 size4");

      // R12: enable dropped while a command waits
      reg_write(2'd3, 32'd0);
      reg_write(2'd2, {3'b0, BASE, 8'd0});
      fill_ring(0, 8, 16, 1'b1);
      ready_mode = 3;
      fifo_empty = 1'b1;
      reg_write(2'd1, 32'h1);
      clear_logs();
      reg_write(2'd0, 32'h1);
      for (int w = 0; w < 50 && !cmd_valid; w++) wait_cyc(1);
      reg_write(2'd1, 32'h0);
      ready_mode = 0;
      wait_cyc(40);
      chk(n_cmd == 1, "R12", "one command after disable", n_cmd, 1);
      chk(bmem[0] == (exp_flags[0] & 32'h7FFF_FFFF), "R12", "current written back",
          bmem[0], exp_flags[0] & 32'h7FFF_FFFF);
      chk(bmem[2] == exp_flags[1], "R12", "next still owned", bmem[2], exp_flags[1]);
      reg_read(2'd2, rd);
      chk(rd[7:0] == 8'd1, "R12", "pointer after disable", rd[7:0], 1);
      chk(done_cnt == 0, "R12", "no done on disable", done_cnt, 0);

      summary();
      $finish;
   end
endmodule